// File: doc/BRIEF.md
# Frame Data Checksum Unit

This block forms the 8-bit checksum that closes a frame on a single-wire vehicle serial bus, or verifies it on reception. A byte-level deserialiser or serialiser feeds it the frame's payload bytes one at a time, after the identifier has been decoded. The identifier, sync and break fields never reach it. A start-of-frame clear opens each frame. It also latches the payload length and the direction for that frame.

The checksum is not a CRC polynomial. It is an 8-bit sum in which every carry out of the top bit is folded back into bit 0 (end-around carry), and the result is inverted. In transmit mode the unit publishes the inverted sum once the last payload byte has been taken. In receive mode it takes one more byte from the same stream as the received checksum. It adds that byte with end-around carry and raises an error flag unless the result is all ones. In both modes a one-cycle done pulse marks the result.

Top module: `fcs_unit`

## Requirements
- R1: After reset, `cks_out` is 0x00 and `cks_done` and `cks_err` are 0. The unit is idle, so bytes offered before the first `sof_clr` produce no done pulse.
- R2: `sof_clr` zeroes the running sum and latches `len_code` and `rx_mode` for the frame. A byte offered in the same cycle as `sof_clr` is ignored.
- R3: Each payload byte is added to the running sum modulo 256. The carry out of bit 7 is then added into bit 0 before the next byte.
- R4: The payload length follows `len_code`: 0 or 1 selects 2 bytes, 2 selects 4 bytes, and 3 selects 8 bytes.
- R5: In transmit mode (`rx_mode`=0), the cycle after the last payload byte is taken, `cks_done` is high for exactly one cycle and `cks_out` equals the bitwise inverse of the final sum.
- R6: In receive mode (`rx_mode`=1), the byte after the last payload byte is the received checksum. The cycle after it is taken, `cks_done` pulses for one cycle and `cks_out` equals the inverse of the payload sum. `cks_err` goes high if the payload sum plus the received byte, with end-around carry, is not 0xFF.
- R7: `cks_err` is never set in transmit mode. Once set, it holds until the next `sof_clr` (cleared the cycle after) or reset.
- R8: Bytes offered after the frame has completed and before the next `sof_clr` are ignored. They cause no done pulse and leave `cks_out` and `cks_err` unchanged.
- R9: A `sof_clr` in the middle of a frame abandons the partial sum. It raises neither done nor error, and the new frame's checksum depends only on its own bytes.
- R10: `cks_out` changes only in a cycle where `cks_done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_clr | input | 1 | Start-of-frame clear; latches length and direction |
| byte_vld | input | 1 | `byte_in` carries a byte this cycle |
| byte_in | input | 8 | Payload byte, or the received checksum in receive mode |
| len_code | input | 2 | Payload length code (see R4) |
| rx_mode | input | 1 | 1 = receive and verify, 0 = transmit and generate |
| cks_out | output | 8 | Computed checksum (inverted end-around-carry sum) |
| cks_done | output | 1 | One-cycle pulse when the result is valid |
| cks_err | output | 1 | Received checksum mismatch, held until next clear |

## Verification
The bench targets sums that carry out of bit 7 on every byte, such as runs of 0xFF and pairs of 0x80. A design that drops the folded carry or adds it one byte late gives a checksum off by one there. It covers every length code, including the duplicate code for two bytes. A counter that decodes the code wrongly pulses done early or late. Received checksums are offered both correct and corrupted, checking that the flag holds and then clears at the next frame. A frame is abandoned mid-way, and bytes arrive after completion and alongside a clear. A design that leaks the stale sum, counts the clash byte, or reopens after completion shows a wrong checksum or a spurious pulse.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int BYTE_W   = 8;
    localparam int MAX_DATA = 8;
    localparam int CNT_W    = $clog2(MAX_DATA + 1);
    localparam int LEN_W    = 2;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    localparam byte_t SUM_GOOD = '1;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_CKS  = 2'd2
    } phase_e;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } dir_e;

    typedef struct packed {
        dir_e dir;
        cnt_t nbytes;
    } frame_cfg_t;

    typedef struct packed {
        logic data;
        logic last;
        logic cks;
    } take_t;

    function automatic byte_t eac_add(byte_t a, byte_t b);
        logic [BYTE_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[BYTE_W-1:0] + byte_t'(s[BYTE_W]);
    endfunction

    function automatic cnt_t len_decode(logic [LEN_W-1:0] code);
        cnt_t n;
        case (code)
            2'd2:    n = cnt_t'(4);
            2'd3:    n = cnt_t'(8);
            default: n = cnt_t'(2);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
    import fcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sof_clr,
    input  logic             byte_vld,
    input  logic [LEN_W-1:0] len_code,
    input  logic             rx_mode,
    output frame_cfg_t       cfg,
    output take_t            take,
    output logic             finish
);

    phase_e     phase_q, phase_d;
    cnt_t       cnt_q, cnt_d;
    frame_cfg_t cfg_q, cfg_d;
    cnt_t       last_idx;
    logic       accept;

    assign last_idx = cnt_t'(cfg_q.nbytes - cnt_t'(1));
    assign accept   = byte_vld && !sof_clr;

    always_comb begin
        take.data = accept && (phase_q == PH_DATA);
        take.last = take.data && (cnt_q == last_idx);
        take.cks  = accept && (phase_q == PH_CKS);
        finish    = (take.last && (cfg_q.dir == DIR_TX)) || take.cks;
    end

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        cfg_d   = cfg_q;
        if (sof_clr) begin
            phase_d    = PH_DATA;
            cnt_d      = '0;
            cfg_d.dir  = rx_mode ? DIR_RX : DIR_TX;
            cfg_d.nbytes = len_decode(len_code);
        end else if (take.data) begin
            cnt_d = cnt_q + cnt_t'(1);
            if (take.last) begin
                phase_d = (cfg_q.dir == DIR_RX) ? PH_CKS : PH_IDLE;
            end
        end else if (take.cks) begin
            phase_d = PH_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            cfg_q   <= '{dir: DIR_TX, nbytes: cnt_t'(2)};
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            cfg_q   <= cfg_d;
        end
    end

    assign cfg = cfg_q;

    // R4: byte count never runs past the decoded length
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= cfg_q.nbytes);

    // R2: a clear opens a fresh frame with an empty count
    a_r2_clear_opens: assert property (@(posedge clk) disable iff (rst)
        sof_clr |=> (phase_q == PH_DATA) && (cnt_q == '0));

    // R6: the checksum byte is only taken once the full payload is in
    a_r6_cks_after_full: assert property (@(posedge clk) disable iff (rst)
        take.cks |-> (cnt_q == cfg_q.nbytes) && (cfg_q.dir == DIR_RX));

    // R8: a completed frame stays idle until the next clear
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE) && !sof_clr |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/fcs_accum.sv
module fcs_accum
    import fcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  take_t take,
    input  logic  finish,
    input  dir_e  dir,
    input  byte_t byte_in,
    output byte_t cks,
    output logic  done,
    output logic  err
);

    byte_t sum_q;
    byte_t sum_next;
    byte_t cks_q;
    logic  done_q;
    logic  err_q;
    logic  mismatch;

    assign sum_next = eac_add(sum_q, byte_in);
    assign mismatch = take.cks && (sum_next != SUM_GOOD);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sum_q <= '0;
        end else if (take.data) begin
            sum_q <= sum_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cks_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) begin
                cks_q <= take.data ? ~sum_next : ~sum_q;
            end
            if (clr) begin
                err_q <= 1'b0;
            end else if (finish && mismatch) begin
                err_q <= 1'b1;
            end
        end
    end

    assign cks  = cks_q;
    assign done = done_q;
    assign err  = err_q;

    // R5: done lasts a single cycle
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R10: result register moves only with done
    a_r10_cks_hold: assert property (@(posedge clk) disable iff (rst)
        !done_q |-> $stable(cks_q));

    // R7: the error flag is a receive-only result
    a_r7_err_rx_only: assert property (@(posedge clk) disable iff (rst)
        err_q |-> (dir == DIR_RX));

    // R7: a new error appears only together with done
    a_r7_err_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> done_q);

    // R9: a clear never yields done or error
    a_r9_clear_quiet: assert property (@(posedge clk) disable iff (rst)
        clr |=> !done_q && !err_q);

endmodule

// File: rtl/fcs_unit.sv
module fcs_unit
    import fcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sof_clr,
    input  logic             byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [LEN_W-1:0] len_code,
    input  logic             rx_mode,
    output logic [BYTE_W-1:0] cks_out,
    output logic             cks_done,
    output logic             cks_err
);

    frame_cfg_t cfg;
    take_t      take;
    logic       finish;
    byte_t      cks_w;

    fcs_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .sof_clr  (sof_clr),
        .byte_vld (byte_vld),
        .len_code (len_code),
        .rx_mode  (rx_mode),
        .cfg      (cfg),
        .take     (take),
        .finish   (finish)
    );

    fcs_accum u_accum (
        .clk     (clk),
        .rst     (rst),
        .clr     (sof_clr),
        .take    (take),
        .finish  (finish),
        .dir     (cfg.dir),
        .byte_in (byte_in),
        .cks     (cks_w),
        .done    (cks_done),
        .err     (cks_err)
    );

    assign cks_out = cks_w;

    // R1: outputs idle in the cycle after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (cks_out == '0) && !cks_done && !cks_err);

endmodule

// File: tb/sim_fcs_unit.sv
`timescale 1ns/1ps
module sim_fcs_unit;

    logic       clk = 1'b0;
    logic       rst;
    logic       sof_clr;
    logic       byte_vld;
    logic [7:0] byte_in;
    logic [1:0] len_code;
    logic       rx_mode;
    logic [7:0] cks_out;
    logic       cks_done;
    logic       cks_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fcs_unit u0 (
        .clk      (clk),
        .rst      (rst),
        .sof_clr  (sof_clr),
        .byte_vld (byte_vld),
        .byte_in  (byte_in),
        .len_code (len_code),
        .rx_mode  (rx_mode),
        .cks_out  (cks_out),
        .cks_done (cks_done),
        .cks_err  (cks_err)
    );

    function automatic logic [7:0] m_add(logic [7:0] a, logic [7:0] b);
        int s;
        s = int'(a) + int'(b);
        if (s > 255) s = s - 256 + 1;
        return 8'(s);
    endfunction

    function automatic int m_len(logic [1:0] c);
        if (c == 2'd3) return 8;
        if (c == 2'd2) return 4;
        return 2;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_frame(input logic [1:0] lc, input logic rx);
        @(negedge clk);
        sof_clr  = 1'b1;
        len_code = lc;
        rx_mode  = rx;
        byte_vld = 1'b0;
        @(negedge clk);
        sof_clr  = 1'b0;
        len_code = $urandom();
        rx_mode  = $urandom();
    endtask

    // drives one byte at a negedge; returns at the next negedge
    task automatic put_byte(input logic [7:0] b, input int gap);
        for (int g = 0; g < gap; g++) @(negedge clk);
        byte_vld = 1'b1;
        byte_in  = b;
        @(negedge clk);
        byte_vld = 1'b0;
        byte_in  = $urandom();
    endtask

    // full frame; data from arr; returns right after done should show
    task automatic frame(input logic [1:0] lc, input logic rx, input logic [7:0] arr[8],
                         input bit corrupt, input bit rnd_gap, input string tag);
        logic [7:0] s = 8'h00;
        logic [7:0] rc;
        int n = m_len(lc);
        clear_frame(lc, rx);
        for (int i = 0; i < n; i++) begin
            s = m_add(s, arr[i]);
            put_byte(arr[i], rnd_gap ? int'($urandom_range(0, 2)) : 0);
            if (!(i == n - 1 && !rx))
                chk(cks_done == 1'b0, {tag, " R4 no early done"}, cks_done, 0);
        end
        if (rx) begin
            rc = ~s;
            if (corrupt) rc = rc ^ 8'(1 << $urandom_range(0, 7));
            put_byte(rc, 0);
            chk(cks_done == 1'b1, {tag, " R6 done"}, cks_done, 1);
            chk(cks_out == ~s, {tag, " R6 cks"}, cks_out, ~s);
            chk(cks_err == (m_add(s, rc) != 8'hFF), {tag, " R6 err"}, cks_err,
                m_add(s, rc) != 8'hFF);
        end else begin
            chk(cks_done == 1'b1, {tag, " R5 done"}, cks_done, 1);
            chk(cks_out == ~s, {tag, " R5/R3 cks"}, cks_out, ~s);
            chk(cks_err == 1'b0, {tag, " R7 tx no err"}, cks_err, 0);
        end
        @(negedge clk);
        chk(cks_done == 1'b0, {tag, " R5 pulse one cycle"}, cks_done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d[8];
        logic [7:0] held;
        logic       held_e;
        void'($urandom(32'd20240611));
        rst = 1'b1; sof_clr = 1'b0; byte_vld = 1'b0; byte_in = 8'h00;
        len_code = 2'd0; rx_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(cks_out == 8'h00, "R1 cks_out", cks_out, 0);
        chk(cks_done == 1'b0, "R1 done", cks_done, 0);
        chk(cks_err == 1'b0, "R1 err", cks_err, 0);
        // R1 bytes before any clear are ignored
        for (int i = 0; i < 10; i++) begin
            put_byte(8'($urandom()), 0);
            chk(cks_done == 1'b0, "R1 idle no done", cks_done, 0);
        end
        chk(cks_out == 8'h00, "R1 idle cks", cks_out, 0);

        // R3 carry on every byte: FF,FF -> sum FF, cks 00
        d = '{8'hFF, 8'hFF, 0, 0, 0, 0, 0, 0};
        frame(2'd0, 1'b0, d, 0, 0, "dir FFFF");
        // R3 80+80 -> 01, cks FE
        d = '{8'h80, 8'h80, 0, 0, 0, 0, 0, 0};
        frame(2'd1, 1'b0, d, 0, 0, "dir 8080");
        chk(cks_out == 8'hFE, "R3 folded carry", cks_out, 8'hFE);
        // R3 eight FF bytes
        d = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
        frame(2'd3, 1'b1, d, 0, 0, "dir 8xFF rx");
        // zeros in receive mode, good checksum FF
        d = '{default: 8'h00};
        frame(2'd2, 1'b1, d, 0, 0, "dir zeros rx");
        chk(cks_err == 1'b0, "R6 zero frame good", cks_err, 0);

        // R7 corrupted checksum holds error, clear drops it
        d = '{8'h12, 8'h34, 8'h56, 8'h78, 0, 0, 0, 0};
        frame(2'd2, 1'b1, d, 1, 0, "dir bad rx");
        held = cks_out;
        held_e = cks_err;
        chk(cks_err == 1'b1, "R7 err set", cks_err, 1);
        // R8 extra bytes ignored
        for (int i = 0; i < 4; i++) begin
            put_byte(8'($urandom()), 0);
            chk(cks_done == 1'b0, "R8 extra no done", cks_done, 0);
        end
        chk(cks_out == held, "R8 cks unchanged", cks_out, held);
        chk(cks_err == held_e, "R7 err held", cks_err, held_e);
        @(negedge clk);
        sof_clr = 1'b1; len_code = 2'd0; rx_mode = 1'b0;
        @(negedge clk);
        sof_clr = 1'b0;
        chk(cks_err == 1'b0, "R7 clear drops err", cks_err, 0);
        chk(cks_out == held, "R10 cks held over clear", cks_out, held);

        // R9 abandon a frame mid-way
        @(negedge clk);
        sof_clr = 1'b1; len_code = 2'd3; rx_mode = 1'b1;
        @(negedge clk);
        sof_clr = 1'b0;
        for (int i = 0; i < 3; i++) put_byte(8'hA5, 0);
        d = '{8'h01, 8'h02, 0, 0, 0, 0, 0, 0};
        frame(2'd0, 1'b0, d, 0, 0, "R9 after abandon");
        chk(cks_out == 8'hFC, "R9 fresh sum only", cks_out, 8'hFC);

        // R2 byte together with clear is ignored
        @(negedge clk);
        sof_clr = 1'b1; len_code = 2'd1; rx_mode = 1'b0;
        byte_vld = 1'b1; byte_in = 8'h55;
        @(negedge clk);
        sof_clr = 1'b0; byte_vld = 1'b0;
        put_byte(8'h10, 0);
        chk(cks_done == 1'b0, "R2 clash byte not counted", cks_done, 0);
        put_byte(8'h20, 0);
        chk(cks_done == 1'b1, "R2 done after two", cks_done, 1);
        chk(cks_out == 8'hCF, "R2 clash byte not summed", cks_out, 8'hCF);

        // random frames
        for (int f = 0; f < 300; f++) begin
            logic [1:0] lc = 2'($urandom());
            logic rx = 1'($urandom());
            for (int i = 0; i < 8; i++) d[i] = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom());
            frame(lc, rx, d, rx && ($urandom_range(0, 1) == 1), 1, "rnd R4");
            if ($urandom_range(0, 3) == 0) begin
                held = cks_out;
                put_byte(8'($urandom()), 0);
                chk(cks_done == 1'b0 && cks_out == held, "rnd R8 extra", cks_out, held);
            end
        end

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule